// File: doc/BRIEF.md
# Latency-Pipelined Multiport RAM

A behavioural word-addressed memory with several kinds of port around one storage array. There are read-only ports, write-only ports and shared read-write ports. Read and write latencies are set by parameters. Each latency is met by passing the port's address, enable and payload through chains of registers before the array is accessed, so the array itself is read combinationally and written on a single edge. With a read latency of zero, a read port is a purely combinational path from address to data.

Writes carry a lane mask whose granularity is a parameter, so a single write can update part of a word. All write-capable ports share one write clock and are resolved in one process with a fixed priority. A read-write port uses a mode bit to pick a read or a write on each access. Its address, enable and mode first go through the stages common to both directions. They then split into a read branch and a write branch, and each branch adds its remaining stages.

When a read arrives at the array with its enable low, the port drives an unknown value. A build-time option instead keeps the last enabled address in each stage and always shows the array word at that held address.

Top module: `mpram_top`

## Requirements
- R1: The mask has LANES = DATA_W / MASK_GRAN bits (one lane when MASK_GRAN is 0). Mask bit l covers data bits [l*LANE_W +: LANE_W]. With a single lane the mask input is ignored and every write updates the whole word.
- R2: A read request (enable high, address) presented before rising edge n appears on that port's data output after edge n+RD_LAT-1 and stays there for one cycle. It is not yet on the output after earlier edges.
- R3: When the enable reaching the array is low (outside the ignore-enable option), the read data output is driven unknown and does not present the stored word.
- R4: A write presented before edge n updates the array at edge n+WR_LAT-1. With RD_LAT equal to WR_LAT, a read of the same address issued in the same cycle returns the new word.
- R5: Lanes whose mask bit is 0, and every address not written, keep their previous contents.
- R6: Writes landing in the same cycle are applied in the order read-write ports, then write-only ports, each by ascending index. On overlapping lanes the later port wins, and disjoint lanes from different ports merge.
- R7: On a read-write port, mode 1 writes (write latency) and mode 0 reads (read latency). While mode is 1 the port's read output is unknown and does not show the array.
- R8: With IGNORE_REN set, each read stage loads its address only while the enable entering that stage is high. The output always shows the array word at the held address, and it follows later writes to that address.
- R9: Reset clears every pending enable stage, so a write already in flight when reset is asserted never reaches the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of the enable stages |
| rd_clk | input | N_RD | One clock per read-only port |
| rd_en | input | N_RD | Read enable per read-only port |
| rd_addr | input | N_RD*AW | Read address, port i in slice i*AW |
| rd_data | output | N_RD*DATA_W | Read data, port i in slice i*DATA_W |
| wr_clk | input | 1 | Clock shared by write-only and read-write ports |
| wr_en | input | N_WR | Write enable per write-only port |
| wr_addr | input | N_WR*AW | Write address per write-only port |
| wr_data | input | N_WR*DATA_W | Write data per write-only port |
| wr_mask | input | N_WR*LANES | Lane mask per write-only port |
| rw_en | input | N_RW | Access enable per read-write port |
| rw_wmode | input | N_RW | 1 = write, 0 = read |
| rw_addr | input | N_RW*AW | Address per read-write port |
| rw_wdata | input | N_RW*DATA_W | Write data per read-write port |
| rw_wmask | input | N_RW*LANES | Lane mask per read-write port |
| rw_rdata | output | N_RW*DATA_W | Read data per read-write port |

## Verification
Reads are tried as single-cycle pulses, with the output sampled one cycle early, in the valid cycle and one cycle late. This separates a wrong stage count from a wrong enable path. Writes are tried full-word, with each single lane, and with an all-zero mask, so lane placement is separated from the treatment of unmasked lanes. Simultaneous writes pit two write-only ports against each other, then a read-write port against a write-only port, with both overlapping and disjoint lanes, which exposes a wrong priority order. A write issued in the same cycle as a read of the same address, and a write cut off by reset, pin down the exact edge on which the array changes. A second instance with the ignore-enable option shows the address being held and the output following the array.

// File: rtl/mpram_pkg.sv
package mpram_pkg;

   // number of mask lanes for a word; granularity 0 means one lane
   function automatic int lane_count(input int data_w, input int gran);
      return (gran == 0) ? 1 : data_w / gran;
   endfunction

   // width of one mask lane
   function automatic int lane_width(input int data_w, input int gran);
      return (gran == 0) ? data_w : gran;
   endfunction

   function automatic int min_int(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/mpram_delay.sv
// Register chain of STAGES stages; STAGES = 0 is a wire.
// CLEARED selects an asynchronously cleared chain (used for enables).
module mpram_delay #(
   parameter int W       = 1,
   parameter int STAGES  = 1,
   parameter bit CLEARED = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic unused_tie;
   assign unused_tie = clk ^ rst_n;

   if (STAGES < 0) begin : g_bad
      $error("mpram_delay: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_wire
      assign q = d;
   end else if (CLEARED) begin : g_clr
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
         end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
         end
      end
      assign q = stg[STAGES-1];
   end else begin : g_plain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/mpram_rd_pipe.sv
// Read request pipeline: plain delay, or address-holding variant.
module mpram_rd_pipe #(
   parameter int AW        = 4,
   parameter int STAGES    = 1,
   parameter bit HOLD_ADDR = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_i,
   input  logic          en_i,
   output logic [AW-1:0] addr_o,
   output logic          en_o
);
   if (!HOLD_ADDR || STAGES == 0) begin : g_plain
      mpram_delay #(.W(1), .STAGES(STAGES), .CLEARED(1'b1)) u_en (
         .clk(clk), .rst_n(rst_n), .d(en_i), .q(en_o));
      mpram_delay #(.W(AW), .STAGES(STAGES), .CLEARED(1'b0)) u_addr (
         .clk(clk), .rst_n(rst_n), .d(addr_i), .q(addr_o));
   end else begin : g_hold
      logic [STAGES-1:0] en_r;
      logic [AW-1:0]     addr_r [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_r <= '0;
            for (int k = 0; k < STAGES; k++) addr_r[k] <= '0;
         end else begin
            en_r[0] <= en_i;
            if (en_i) addr_r[0] <= addr_i;
            for (int k = 1; k < STAGES; k++) begin
               en_r[k] <= en_r[k-1];
               if (en_r[k-1]) addr_r[k] <= addr_r[k-1];
            end
         end
      end
      assign en_o   = en_r[STAGES-1];
      assign addr_o = addr_r[STAGES-1];
   end

   // enable must drain STAGES cycles after the last request
   if (!HOLD_ADDR && STAGES > 0) begin : g_chk
      localparam int CW = $clog2(STAGES + 1) + 1;
      logic [CW-1:0] idle_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        idle_cnt <= CW'(STAGES);
         else if (en_i)                     idle_cnt <= '0;
         else if (idle_cnt != CW'(STAGES))  idle_cnt <= idle_cnt + 1'b1;
      end
      p_rd_en_drains_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (idle_cnt == CW'(STAGES)) |-> !en_o);
   end
endmodule

// File: rtl/mpram_top.sv
module mpram_top
   import mpram_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter int DATA_W     = 16,
   parameter int MASK_GRAN  = 8,
   parameter int RD_LAT     = 2,
   parameter int WR_LAT     = 2,
   parameter int N_RD       = 2,
   parameter int N_WR       = 2,
   parameter int N_RW       = 1,
   parameter bit IGNORE_REN = 1'b0,
   localparam int AW        = $clog2(DEPTH),
   localparam int LANES     = lane_count(DATA_W, MASK_GRAN)
) (
   input  logic                     rst_n,
   input  logic [N_RD-1:0]          rd_clk,
   input  logic [N_RD-1:0]          rd_en,
   input  logic [N_RD*AW-1:0]       rd_addr,
   output logic [N_RD*DATA_W-1:0]   rd_data,
   input  logic                     wr_clk,
   input  logic [N_WR-1:0]          wr_en,
   input  logic [N_WR*AW-1:0]       wr_addr,
   input  logic [N_WR*DATA_W-1:0]   wr_data,
   input  logic [N_WR*LANES-1:0]    wr_mask,
   input  logic [N_RW-1:0]          rw_en,
   input  logic [N_RW-1:0]          rw_wmode,
   input  logic [N_RW*AW-1:0]       rw_addr,
   input  logic [N_RW*DATA_W-1:0]   rw_wdata,
   input  logic [N_RW*LANES-1:0]    rw_wmask,
   output logic [N_RW*DATA_W-1:0]   rw_rdata
);
   localparam int LANE_W = lane_width(DATA_W, MASK_GRAN);
   localparam int WSTG   = WR_LAT - 1;
   localparam int RWC    = min_int(RD_LAT, WSTG);
   localparam int RW_RX  = RD_LAT - RWC;
   localparam int RW_WX  = WSTG - RWC;
   localparam int LP     = N_WR - 1;

   // elaboration-time parameter checks
   if (DEPTH < 2)                                   begin : g_e0 $error("DEPTH must be at least 2"); end
   if (RD_LAT < 0)                                  begin : g_e1 $error("RD_LAT must be >= 0"); end
   if (WR_LAT < 1)                                  begin : g_e2 $error("WR_LAT must be >= 1"); end
   if (MASK_GRAN != 0 && DATA_W % MASK_GRAN != 0)   begin : g_e3 $error("MASK_GRAN must divide DATA_W"); end
   if (N_RD < 1 || N_WR < 1 || N_RW < 1)            begin : g_e4 $error("each port count must be >= 1"); end

   logic [DATA_W-1:0] mem [DEPTH];

   // staged write requests, one entry per port
   logic [N_RW-1:0]   rw_wen_q;
   logic [AW-1:0]     rw_waddr_q [N_RW];
   logic [DATA_W-1:0] rw_wdata_q [N_RW];
   logic [LANES-1:0]  rw_mask_eff [N_RW];
   logic [N_WR-1:0]   wr_en_q;
   logic [AW-1:0]     wr_addr_q [N_WR];
   logic [DATA_W-1:0] wr_data_q [N_WR];
   logic [LANES-1:0]  wr_mask_eff [N_WR];

   // ---------------- read-only ports ----------------
   for (genvar i = 0; i < N_RD; i++) begin : g_rd
      logic [AW-1:0] a_q;
      logic          e_q;
      mpram_rd_pipe #(.AW(AW), .STAGES(RD_LAT), .HOLD_ADDR(IGNORE_REN)) u_pipe (
         .clk(rd_clk[i]), .rst_n(rst_n),
         .addr_i(rd_addr[i*AW +: AW]), .en_i(rd_en[i]),
         .addr_o(a_q), .en_o(e_q));
      assign rd_data[i*DATA_W +: DATA_W] =
         (IGNORE_REN || e_q) ? mem[a_q] : {DATA_W{1'bx}};
   end

   // ---------------- read-write ports ----------------
   for (genvar p = 0; p < N_RW; p++) begin : g_rw
      logic [AW-1:0]    c_addr, r_addr;
      logic [1:0]       c_ctl, w_ctl;      // {mode, enable}
      logic             r_en;
      logic [LANES-1:0] m_q;

      // stages common to both directions
      mpram_delay #(.W(AW), .STAGES(RWC), .CLEARED(1'b0)) u_c_addr (
         .clk(wr_clk), .rst_n(rst_n), .d(rw_addr[p*AW +: AW]), .q(c_addr));
      mpram_delay #(.W(2), .STAGES(RWC), .CLEARED(1'b1)) u_c_ctl (
         .clk(wr_clk), .rst_n(rst_n), .d({rw_wmode[p], rw_en[p]}), .q(c_ctl));

      // read branch: enabled only with mode 0
      mpram_rd_pipe #(.AW(AW), .STAGES(RW_RX), .HOLD_ADDR(IGNORE_REN)) u_rpipe (
         .clk(wr_clk), .rst_n(rst_n),
         .addr_i(c_addr), .en_i(c_ctl[0] & ~c_ctl[1]),
         .addr_o(r_addr), .en_o(r_en));
      assign rw_rdata[p*DATA_W +: DATA_W] =
         (IGNORE_REN || r_en) ? mem[r_addr] : {DATA_W{1'bx}};

      // write branch
      mpram_delay #(.W(AW), .STAGES(RW_WX), .CLEARED(1'b0)) u_w_addr (
         .clk(wr_clk), .rst_n(rst_n), .d(c_addr), .q(rw_waddr_q[p]));
      mpram_delay #(.W(2), .STAGES(RW_WX), .CLEARED(1'b1)) u_w_ctl (
         .clk(wr_clk), .rst_n(rst_n), .d(c_ctl), .q(w_ctl));
      assign rw_wen_q[p] = w_ctl[0] & w_ctl[1];
      mpram_delay #(.W(DATA_W), .STAGES(WSTG), .CLEARED(1'b0)) u_w_data (
         .clk(wr_clk), .rst_n(rst_n), .d(rw_wdata[p*DATA_W +: DATA_W]), .q(rw_wdata_q[p]));
      mpram_delay #(.W(LANES), .STAGES(WSTG), .CLEARED(1'b0)) u_w_mask (
         .clk(wr_clk), .rst_n(rst_n), .d(rw_wmask[p*LANES +: LANES]), .q(m_q));
      assign rw_mask_eff[p] = (LANES > 1) ? m_q : {LANES{1'b1}};
   end

   // ---------------- write-only ports ----------------
   for (genvar j = 0; j < N_WR; j++) begin : g_wr
      logic             e_q;
      logic [LANES-1:0] m_q;
      mpram_delay #(.W(1), .STAGES(WSTG), .CLEARED(1'b1)) u_en (
         .clk(wr_clk), .rst_n(rst_n), .d(wr_en[j]), .q(e_q));
      mpram_delay #(.W(AW), .STAGES(WSTG), .CLEARED(1'b0)) u_addr (
         .clk(wr_clk), .rst_n(rst_n), .d(wr_addr[j*AW +: AW]), .q(wr_addr_q[j]));
      mpram_delay #(.W(DATA_W), .STAGES(WSTG), .CLEARED(1'b0)) u_data (
         .clk(wr_clk), .rst_n(rst_n), .d(wr_data[j*DATA_W +: DATA_W]), .q(wr_data_q[j]));
      mpram_delay #(.W(LANES), .STAGES(WSTG), .CLEARED(1'b0)) u_mask (
         .clk(wr_clk), .rst_n(rst_n), .d(wr_mask[j*LANES +: LANES]), .q(m_q));
      assign wr_en_q[j]     = e_q;
      assign wr_mask_eff[j] = (LANES > 1) ? m_q : {LANES{1'b1}};
   end

   // ---------------- array update, fixed port order ----------------
   always_ff @(posedge wr_clk) begin
      for (int p = 0; p < N_RW; p++) begin
         if (rw_wen_q[p]) begin
            for (int l = 0; l < LANES; l++) begin
               if (rw_mask_eff[p][l])
                  mem[rw_waddr_q[p]][l*LANE_W +: LANE_W] <= rw_wdata_q[p][l*LANE_W +: LANE_W];
            end
         end
      end
      for (int j = 0; j < N_WR; j++) begin
         if (wr_en_q[j]) begin
            for (int l = 0; l < LANES; l++) begin
               if (wr_mask_eff[j][l])
                  mem[wr_addr_q[j]][l*LANE_W +: LANE_W] <= wr_data_q[j][l*LANE_W +: LANE_W];
            end
         end
      end
   end

   // ---------------- assertions ----------------
   logic other_wr;
   always_comb begin
      other_wr = |rw_wen_q;
      for (int j = 0; j < LP; j++) other_wr = other_wr | wr_en_q[j];
   end

   // last write-only port always wins its lanes
   p_last_wins_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_en_q[LP] && wr_mask_eff[LP][0]) |=>
      (mem[$past(wr_addr_q[LP])][LANE_W-1:0] === $past(wr_data_q[LP][LANE_W-1:0])));

   // a cleared lane is left untouched when no other port writes
   p_lane_kept_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_en_q[LP] && !wr_mask_eff[LP][0] && !other_wr) |=>
      (mem[$past(wr_addr_q[LP])][LANE_W-1:0] === $past(mem[wr_addr_q[LP]][LANE_W-1:0])));

   // with no write in flight the array does not change
   p_idle_hold_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!wr_en_q[LP] && !other_wr) |=>
      (mem[$past(wr_addr_q[LP])] === $past(mem[wr_addr_q[LP]])));
endmodule

// File: tb/mpram_top_tb_top.sv
module mpram_top_tb_top;
   logic clk = 1'b0;
   logic rst_n;
   always #10 clk = ~clk;   // 50 MHz

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // main instance: RD_LAT 2, WR_LAT 2, two lanes of 8 bits
   logic [1:0]  rd_en;   logic [7:0]  rd_addr;  logic [31:0] rd_data;
   logic [1:0]  wr_en;   logic [7:0]  wr_addr;  logic [31:0] wr_data;  logic [3:0] wr_mask;
   logic [0:0]  rw_en;   logic [0:0]  rw_wmode; logic [3:0]  rw_addr;
   logic [15:0] rw_wdata; logic [1:0] rw_wmask; logic [15:0] rw_rdata;

   mpram_top dut_i (
      .rst_n(rst_n), .rd_clk({clk, clk}), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
      .rw_en(rw_en), .rw_wmode(rw_wmode), .rw_addr(rw_addr), .rw_wdata(rw_wdata),
      .rw_wmask(rw_wmask), .rw_rdata(rw_rdata));

   // second instance: address-holding reads, RD_LAT 1, WR_LAT 1
   logic [1:0]  i_rd_en;  logic [7:0] i_rd_addr; logic [31:0] i_rd_data;
   logic [1:0]  i_wr_en;  logic [7:0] i_wr_addr; logic [31:0] i_wr_data; logic [3:0] i_wr_mask;
   logic [15:0] i_rw_rdata;

   mpram_top #(.RD_LAT(1), .WR_LAT(1), .IGNORE_REN(1'b1)) dut_ign_i (
      .rst_n(rst_n), .rd_clk({clk, clk}), .rd_en(i_rd_en), .rd_addr(i_rd_addr), .rd_data(i_rd_data),
      .wr_clk(clk), .wr_en(i_wr_en), .wr_addr(i_wr_addr), .wr_data(i_wr_data), .wr_mask(i_wr_mask),
      .rw_en(1'b0), .rw_wmode(1'b0), .rw_addr(4'd0), .rw_wdata(16'd0),
      .rw_wmask(2'b00), .rw_rdata(i_rw_rdata));

   logic [15:0] ref_mem [16];

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic check_not(input string req, input logic [15:0] got, input logic [15:0] bad);
      n_chk++;
      if (got === bad) begin
         n_bad++;
         $display("FAIL %s: got %h expected any value other than %h", req, got, bad);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic quiet();
      rd_en = '0; wr_en = '0; rw_en = '0; rw_wmode = '0;
      i_rd_en = '0; i_wr_en = '0;
   endtask

   // R1: lane l covers bits [l*8 +: 8]
   task automatic ref_apply(input int a, input logic [15:0] d, input logic [1:0] m);
      for (int l = 0; l < 2; l++)
         if (m[l]) ref_mem[a][l*8 +: 8] = d[l*8 +: 8];
   endtask

   task automatic drive_wr(input int p, input int a, input logic [15:0] d, input logic [1:0] m);
      wr_en[p] = 1'b1; wr_addr[p*4 +: 4] = 4'(a);
      wr_data[p*16 +: 16] = d; wr_mask[p*2 +: 2] = m;
   endtask

   task automatic wr_one(input int p, input int a, input logic [15:0] d, input logic [1:0] m);
      drive_wr(p, a, d, m);
      step(); quiet(); step();
      ref_apply(a, d, m);
   endtask

   task automatic rd_one(input int p, input int a, output logic [15:0] got);
      rd_en[p] = 1'b1; rd_addr[p*4 +: 4] = 4'(a);
      step(); quiet(); step();
      got = rd_data[p*16 +: 16];
   endtask

   task automatic t_basic();
      logic [15:0] g;
      wr_one(0, 5, 16'h1234, 2'b11);
      rd_one(0, 5, g); check("R2 port0", g, ref_mem[5]);
      rd_one(1, 5, g); check("R2 port1", g, ref_mem[5]);
      wr_one(1, 6, 16'hBEEF, 2'b11);
      // one edge after request the word must not be shown yet
      rd_en[1] = 1'b1; rd_addr[7:4] = 4'd6;
      step(); quiet();
      check_not("R2 early", rd_data[31:16], 16'hBEEF);
      step(); check("R2 on time", rd_data[31:16], 16'hBEEF);
   endtask

   task automatic t_disabled();
      logic [15:0] g;
      rd_one(0, 5, g);
      step();
      check_not("R3 after pulse", rd_data[15:0], 16'h1234);
      check_not("R3 idle port", rd_data[31:16], 16'hBEEF);
   endtask

   task automatic t_same_cycle();
      drive_wr(0, 5, 16'h5A3C, 2'b11);
      rd_en[0] = 1'b1; rd_addr[3:0] = 4'd5;
      step(); quiet(); step();
      ref_apply(5, 16'h5A3C, 2'b11);
      check("R4 same-cycle read", rd_data[15:0], 16'h5A3C);
   endtask

   task automatic t_mask();
      logic [15:0] g;
      wr_one(0, 7, 16'hAAAA, 2'b11);
      wr_one(0, 7, 16'h1155, 2'b01);
      rd_one(0, 7, g); check("R1 R5 low lane", g, 16'hAA55);
      wr_one(0, 7, 16'h33FF, 2'b10);
      rd_one(0, 7, g); check("R1 R5 high lane", g, 16'h3355);
      wr_one(0, 7, 16'hFFFF, 2'b00);
      rd_one(0, 7, g); check("R5 empty mask", g, 16'h3355);
      rd_one(1, 5, g); check("R5 other address", g, 16'h5A3C);
   endtask

   task automatic t_collide();
      logic [15:0] g;
      drive_wr(0, 8, 16'h1111, 2'b11); drive_wr(1, 8, 16'h2222, 2'b11);
      step(); quiet(); step();
      ref_apply(8, 16'h1111, 2'b11); ref_apply(8, 16'h2222, 2'b11);
      rd_one(0, 8, g); check("R6 W1 over W0", g, ref_mem[8]);
      drive_wr(0, 8, 16'h3333, 2'b11); drive_wr(1, 8, 16'h4444, 2'b10);
      step(); quiet(); step();
      ref_apply(8, 16'h3333, 2'b11); ref_apply(8, 16'h4444, 2'b10);
      rd_one(0, 8, g); check("R6 lane merge", g, 16'h4433);
      rw_en = 1'b1; rw_wmode = 1'b1; rw_addr = 4'd8; rw_wdata = 16'h5555; rw_wmask = 2'b11;
      drive_wr(0, 8, 16'h6666, 2'b11);
      step(); quiet(); step();
      ref_apply(8, 16'h5555, 2'b11); ref_apply(8, 16'h6666, 2'b11);
      rd_one(1, 8, g); check("R6 W0 over RW0", g, 16'h6666);
   endtask

   task automatic t_rw();
      logic [15:0] g;
      rw_en = 1'b1; rw_wmode = 1'b1; rw_addr = 4'd9; rw_wdata = 16'h7E81; rw_wmask = 2'b11;
      step(); quiet(); step();
      ref_apply(9, 16'h7E81, 2'b11);
      rw_en = 1'b1; rw_wmode = 1'b0; rw_addr = 4'd9;
      step(); quiet(); step();
      check("R7 rw read", rw_rdata, ref_mem[9]);
      rd_one(0, 9, g); check("R7 rw write seen by R0", g, 16'h7E81);
      rw_en = 1'b1; rw_wmode = 1'b1; rw_addr = 4'd9; rw_wdata = 16'h0F0F; rw_wmask = 2'b01;
      step(); quiet(); step();
      ref_apply(9, 16'h0F0F, 2'b01);
      check_not("R7 no read in write mode", rw_rdata, 16'h7E0F);
      rd_one(1, 9, g); check("R7 masked rw write", g, 16'h7E0F);
   endtask

   task automatic t_reset();
      logic [15:0] g;
      wr_one(0, 3, 16'hAAAA, 2'b11);
      drive_wr(0, 3, 16'h5555, 2'b11);
      step();
      rst_n = 1'b0; quiet();
      step();
      rst_n = 1'b1;
      step(); step();
      rd_one(0, 3, g); check("R9 in-flight write dropped", g, 16'hAAAA);
   endtask

   task automatic t_hold();
      i_wr_en[0] = 1'b1; i_wr_addr[3:0] = 4'd1; i_wr_data[15:0] = 16'h1234; i_wr_mask[1:0] = 2'b11;
      step();
      i_wr_addr[3:0] = 4'd2; i_wr_data[15:0] = 16'h4321;
      step(); quiet();
      i_rd_en[0] = 1'b1; i_rd_addr[3:0] = 4'd1;
      step();
      i_rd_en[0] = 1'b0; i_rd_addr[3:0] = 4'd2;
      step(); step();
      check("R8 address held", i_rd_data[15:0], 16'h1234);
      i_wr_en[0] = 1'b1; i_wr_addr[3:0] = 4'd1; i_wr_data[15:0] = 16'h0BAD;
      step(); quiet();
      check("R8 follows array", i_rd_data[15:0], 16'h0BAD);
      i_rd_en[0] = 1'b1; i_rd_addr[3:0] = 4'd2;
      step(); quiet();
      check("R8 new address", i_rd_data[15:0], 16'h4321);
   endtask

   initial begin
      rst_n = 1'b0;
      quiet();
      rd_addr = '0; wr_addr = '0; wr_data = '0; wr_mask = '0;
      rw_addr = '0; rw_wdata = '0; rw_wmask = '0;
      i_rd_addr = '0; i_wr_addr = '0; i_wr_data = '0; i_wr_mask = '0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_basic();
      t_disabled();
      t_same_cycle();
      t_mask();
      t_collide();
      t_rw();
      t_reset();
      t_hold();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog (all requirements): got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule